// File: doc/BRIEF.md
# Exception Cause Priority Selector

This combinational block looks at a 16-bit vector of raised exception flags, where bit n is set when the exception with cause number n has been raised. It reports whether any eligible flag is set and gives the 4-bit cause number of the single winner. The winner is picked from a fixed ranking that does not follow numeric order.

A 2-bit mode input chooses which flags may compete. The first mode lets every defined cause compete. The second keeps only the causes that instruction fetch and decode can raise. The third keeps only the flags enabled by a 16-bit per-unit enable mask. Masking is applied before ranking, so a masked-out flag can never hide a lower-ranked flag that is still eligible.

Top module: `exc_cause_sel`

## Requirements
- R1: When `hit_valid` is high, `hit_cause` is the bit index of the winning flag in `exc_vec`, written as an unsigned 4-bit number.
- R2: Among the eligible raised flags, the winner is the one that ranks highest in this list, highest first: 3, 12, 1, 2, 0, 11, 9, 8, 15, 13, 7, 5, 6, 4.
- R3: With `sel_mode` = 2'b00, every defined cause (0 to 9, 11, 12, 13, 15) is eligible, and `unit_en` has no effect.
- R4: With `sel_mode` = 2'b01, only causes 0, 1, 2 and 12 are eligible. All other flags are treated as zero before ranking.
- R5: With `sel_mode` = 2'b10, a defined cause is eligible only when its bit in `unit_en` is 1. Flags whose enable bit is 0 are treated as zero before ranking.
- R6: `sel_mode` = 2'b11 selects exactly the same causes as 2'b00.
- R7: Bits 10 and 14 of `exc_vec` are never eligible in any mode and never affect either output.
- R8: When no eligible flag is raised, `hit_valid` is 0 and `hit_cause` is 0.
- R9: When exactly one eligible flag is raised, `hit_valid` is 1 and `hit_cause` equals that flag's index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exc_vec | input | 16 | Raised exception flags, indexed by cause number |
| sel_mode | input | 2 | Eligibility mode: 00 all, 01 fetch subset, 10 per-unit mask, 11 same as 00 |
| unit_en | input | 16 | Per-unit enable mask, used only in mode 10 |
| hit_valid | output | 1 | An eligible flag is raised |
| hit_cause | output | 4 | Cause number of the winning flag, or 0 when none |

## Verification
The assertions are immediate checks that run whenever the inputs change. They assume that every input holds a defined 0 or 1 value, so that the masked vector, the rank grants and the encoded cause always agree. The bench drives only 2-state values and changes the inputs half a clock period before it samples the outputs, so every check sees settled logic. It sets every single flag in every mode, and it draws multi-flag vectors and enable masks from the full 16-bit range, including the two undefined bit positions.

// File: rtl/exc_sel_pkg.sv
package exc_sel_pkg;
  localparam int VEC_W   = 16;
  localparam int CAUSE_W = 4;
  localparam int RANK_N  = 14;
  localparam int MODE_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    SEL_ALL     = 2'b00,
    SEL_FETCH   = 2'b01,
    SEL_UNIT    = 2'b10,
    SEL_ALL_ALT = 2'b11
  } sel_mode_e;

  // causes that exist at all (bits 10 and 14 are holes)
  localparam logic [VEC_W-1:0] DEFINED_MASK = 16'hBBFF;
  // causes raised by fetch/decode: 0, 1, 2, 12
  localparam logic [VEC_W-1:0] FETCH_MASK   = 16'h1007;

  // rank 0 is the strongest
  function automatic logic [CAUSE_W-1:0] cause_at_rank(input int r);
    case (r)
      0:       return 4'd3;
      1:       return 4'd12;
      2:       return 4'd1;
      3:       return 4'd2;
      4:       return 4'd0;
      5:       return 4'd11;
      6:       return 4'd9;
      7:       return 4'd8;
      8:       return 4'd15;
      9:       return 4'd13;
      10:      return 4'd7;
      11:      return 4'd5;
      12:      return 4'd6;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] eligible_mask(input logic [MODE_W-1:0] mode,
                                                    input logic [VEC_W-1:0] unit_en);
    logic [VEC_W-1:0] m;
    case (mode)
      SEL_FETCH: m = FETCH_MASK;
      SEL_UNIT:  m = unit_en;
      default:   m = {VEC_W{1'b1}};
    endcase
    return m & DEFINED_MASK;
  endfunction
endpackage

// File: rtl/exc_mask_gate.sv
module exc_mask_gate
  import exc_sel_pkg::*;
(
  input  logic [VEC_W-1:0]  raw_vec,
  input  logic [MODE_W-1:0] mode,
  input  logic [VEC_W-1:0]  unit_en,
  output logic [VEC_W-1:0]  masked_vec
);
  logic [VEC_W-1:0] keep_w;

  assign keep_w     = eligible_mask(mode, unit_en);
  assign masked_vec = raw_vec & keep_w;

  always_comb begin
    // R7: holes never pass
    p_holes_dropped_r7: assert (masked_vec[10] == 1'b0 && masked_vec[14] == 1'b0);
    // R4: fetch mode keeps only fetch causes
    if (mode == SEL_FETCH)
      p_fetch_subset_r4: assert ((masked_vec & ~FETCH_MASK) == '0);
    // R5: unit mode keeps only enabled bits
    if (mode == SEL_UNIT)
      p_unit_subset_r5: assert ((masked_vec & ~unit_en) == '0);
    // nothing appears that was not raised
    p_no_new_flag_r1: assert ((masked_vec & ~raw_vec) == '0);
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick
  import exc_sel_pkg::*;
(
  input  logic [VEC_W-1:0]   cand_vec,
  output logic               pick_valid,
  output logic [CAUSE_W-1:0] pick_cause
);
  logic [RANK_N-1:0]  rank_hit;
  logic [RANK_N-1:0]  rank_grant;
  logic [RANK_N:0]    seen_above;
  logic [CAUSE_W-1:0] rank_code [RANK_N];

  assign seen_above[0] = 1'b0;

  for (genvar r = 0; r < RANK_N; r++) begin : g_rank
    localparam logic [CAUSE_W-1:0] CODE = cause_at_rank(r);
    assign rank_code[r]     = CODE;
    assign rank_hit[r]      = cand_vec[CODE];
    assign rank_grant[r]    = rank_hit[r] & ~seen_above[r];
    assign seen_above[r+1]  = seen_above[r] | rank_hit[r];
  end

  assign pick_valid = seen_above[RANK_N];

  always_comb begin
    pick_cause = '0;
    for (int r = 0; r < RANK_N; r++)
      pick_cause |= rank_code[r] & {CAUSE_W{rank_grant[r]}};
  end

  always_comb begin
    // R2: at most one rank wins
    p_single_grant_r2: assert ($onehot0(rank_grant));
    // R8: valid exactly when a candidate is present
    p_valid_matches_r8: assert (pick_valid == (cand_vec != '0));
    // R8: idle output is zero
    if (!pick_valid)
      p_idle_zero_r8: assert (pick_cause == '0);
    // R1: the reported cause is a raised candidate
    if (pick_valid)
      p_cause_raised_r1: assert (cand_vec[pick_cause]);
  end
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_sel_pkg::*;
(
  input  logic [15:0] exc_vec,
  input  logic [1:0]  sel_mode,
  input  logic [15:0] unit_en,
  output logic        hit_valid,
  output logic [3:0]  hit_cause
);
  logic [VEC_W-1:0] masked_w;

  exc_mask_gate i_gate (
    .raw_vec    (exc_vec),
    .mode       (sel_mode),
    .unit_en    (unit_en),
    .masked_vec (masked_w)
  );

  exc_prio_pick i_pick (
    .cand_vec   (masked_w),
    .pick_valid (hit_valid),
    .pick_cause (hit_cause)
  );

  always_comb begin
    // R7: a hole index is never reported
    if (hit_valid)
      p_no_hole_cause_r7: assert (hit_cause != 4'd10 && hit_cause != 4'd14);
    // R4: fetch mode only reports fetch causes
    if (hit_valid && sel_mode == SEL_FETCH)
      p_fetch_cause_r4: assert (hit_cause == 4'd0 || hit_cause == 4'd1 ||
                                hit_cause == 4'd2 || hit_cause == 4'd12);
  end
endmodule

// File: tb/test_exc_cause_sel.sv
module test_exc_cause_sel;
  logic        clk = 1'b0;
  logic [15:0] exc_vec = '0;
  logic [1:0]  sel_mode = 2'b00;
  logic [15:0] unit_en = '0;
  logic        hit_valid;
  logic [3:0]  hit_cause;
  int total = 0;
  int bad = 0;

  // ranking as nibbles, strongest first
  localparam logic [55:0] ORDER = 56'h3C120B98FD7564;

  always #2 clk = ~clk;

  exc_cause_sel i_exc_cause_sel (
    .exc_vec(exc_vec), .sel_mode(sel_mode), .unit_en(unit_en),
    .hit_valid(hit_valid), .hit_cause(hit_cause)
  );

  function automatic logic [4:0] ref_pick(input logic [15:0] v, input logic [1:0] m,
                                          input logic [15:0] en);
    logic [15:0] e;
    e = v;
    if (m == 2'b01) e = e & 16'b0001_0000_0000_0111;
    if (m == 2'b10) e = e & en;
    e[10] = 1'b0;
    e[14] = 1'b0;
    for (int k = 13; k >= 0; k--) begin
      logic [3:0] c;
      c = ORDER[k*4 +: 4];
      if (e[c]) return {1'b1, c};
    end
    return 5'd0;
  endfunction

  task automatic apply_check(input logic [15:0] v, input logic [1:0] m,
                             input logic [15:0] en, input string req);
    logic [4:0] exp;
    @(posedge clk);
    exc_vec = v; sel_mode = m; unit_en = en;
    @(negedge clk);
    exp = ref_pick(v, m, en);
    total++;
    if ({hit_valid, hit_cause} !== exp) begin
      bad++;
      $display("FAIL %s vec=%h mode=%0d en=%h got v=%0b c=%0d exp v=%0b c=%0d",
               req, v, m, en, hit_valid, hit_cause, exp[4], exp[3:0]);
    end
  endtask

  task automatic t_idle();
    apply_check(16'h0000, 2'b00, 16'h0000, "R8");
    apply_check(16'h0000, 2'b10, 16'hFFFF, "R8");
    apply_check(16'h4400, 2'b00, 16'hFFFF, "R7 R8");
  endtask

  task automatic t_onehot();
    for (int m = 0; m < 4; m++)
      for (int b = 0; b < 16; b++)
        apply_check(16'(1 << b), 2'(m), 16'hFFFF, "R9 R1 R7");
  endtask

  task automatic t_ranking();
    apply_check(16'h1008, 2'b00, 16'h0, "R2");   // 3 beats 12
    apply_check(16'h1002, 2'b00, 16'h0, "R2");   // 12 beats 1
    apply_check(16'h0801, 2'b00, 16'h0, "R2");   // 0 beats 11
    apply_check(16'h0050, 2'b00, 16'h0, "R2");   // 6 beats 4
    apply_check(16'hA000, 2'b00, 16'h0, "R2");   // 15 beats 13
    apply_check(16'hBBFF, 2'b00, 16'h0, "R2");
  endtask

  task automatic t_fetch();
    apply_check(16'h0008, 2'b01, 16'hFFFF, "R4");  // breakpoint filtered
    apply_check(16'h100F, 2'b01, 16'h0000, "R4");
    apply_check(16'hEFF8, 2'b01, 16'hFFFF, "R4");
  endtask

  task automatic t_unit();
    apply_check(16'h1008, 2'b10, 16'h1000, "R5");  // winner disabled
    apply_check(16'hFFFF, 2'b10, 16'h0000, "R5");
    apply_check(16'hFFFF, 2'b10, 16'h0030, "R5");
    apply_check(16'h0400, 2'b10, 16'h0400, "R5 R7");
  endtask

  task automatic t_modes_random();
    for (int i = 0; i < 300; i++) begin
      logic [15:0] v, en;
      v = 16'($urandom); en = 16'($urandom);
      apply_check(v, 2'(i % 4), en, "R3 R4 R5 R6");
    end
    apply_check(16'h0020, 2'b00, 16'h0000, "R3");  // unit_en ignored
    apply_check(16'h0020, 2'b11, 16'h0000, "R6");
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_idle();
    t_onehot();
    t_ranking();
    t_fetch();
    t_unit();
    t_modes_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule